// File: doc/BRIEF.md
# Configuration Shadow Capture

This block receives a time-multiplexed configuration bus from a link core that runs on a different clock. Each word on the bus is tagged with a 4-bit slot number, and the producer steps through all sixteen slots in a fixed, repeating order. A toggle line marks each new word. The block moves that toggle into the local clock domain. On every change of the toggle it copies the word into the shadow register for the tagged slot. From those shadows it presents every configuration field as a separate output.

Two wide prefetchable window values are 44 bits long, and each is split across a pair of slots. The block joins the two halves. It also turns the two size codes in the device control word into byte counts: one code for maximum payload and one for maximum read request. Codes that have no defined size raise a flag instead of changing the count. A flag goes high once every slot has been written at least once since reset.

Top module: `cfg_shadow_capture`

## Requirements
- R1: After reset all field outputs, both byte counts, both reserved flags and `all_valid` are zero.
- R2: Each change of `cfg_tog`, rising or falling, stores `cfg_data` into the shadow of slot `cfg_addr`. The stored value reaches the outputs within five local clock cycles.
- R3: Changes on `cfg_addr` or `cfg_data` with no toggle change leave every output unchanged.
- R4: Slot 0 gives `dev_ctl` from data bits 31:16 and `dev_ctl2` from bits 15:0.
- R5: The payload size code is `dev_ctl` bits 7:5 and the read request size code is `dev_ctl` bits 14:12. Codes 0 to 5 set the matching byte count to 128 shifted left by the code, so 128 up to 4096, and clear that code's reserved flag.
- R6: A size code of 6 or 7 sets that code's reserved flag and leaves its byte count at its previous value.
- R7: Slot 4 gives `sec_sts` (bits 31:16), `sec_bus` (15:8) and `sub_bus` (7:0). Slots 5 and 6 give `io_base` and `io_limit` from bits 19:0, and their bits 31:20 are ignored.
- R8: `pf_base` is {slot 9 bits 11:0, slot 8 bits 31:0}. `pf_limit` is {slot 11 bits 11:0, slot 10 bits 31:0}. The upper 20 bits of slots 9 and 11 are ignored.
- R9: `bus_dev` is slot 15 bits 12:0, and the higher bits of that slot are ignored.
- R10: `all_valid` is high only once each of the 16 slots has been captured at least once since reset, and it stays high after that.
- R11: The remaining slots map as follows:
  - slot 1 bits 31:0 to `slot_ctl_sts`
  - slot 2 bits 31:16 to `link_ctl` and 15:0 to `link_ctl2`
  - slot 3 bits 23:8 to `prim_sts` and 7:0 to `root_ctl`
  - slot 7 bits 23:12 to `np_base` and 11:0 to `np_limit`
  - slot 12 to `pm_ctl_sts`
  - slot 13 bits 31:16 to `msix_ctl` and 15:0 to `msi_ctl`
  - slot 14 bits 23:0 to `tc_vc_map`

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_tog | input | 1 | Write toggle from the producer's clock domain |
| cfg_addr | input | 4 | Slot number of the current word |
| cfg_data | input | 32 | Current multiplexed configuration word |
| dev_ctl | output | 16 | Device control/status |
| dev_ctl2 | output | 16 | Second device control |
| slot_ctl_sts | output | 32 | Slot control/status |
| link_ctl | output | 16 | Link control/status |
| link_ctl2 | output | 16 | Second link control |
| prim_sts | output | 16 | Primary status |
| root_ctl | output | 8 | Root control |
| sec_sts | output | 16 | Secondary status |
| sec_bus | output | 8 | Secondary bus number |
| sub_bus | output | 8 | Subordinate bus number |
| io_base | output | 20 | I/O window base |
| io_limit | output | 20 | I/O window limit |
| np_base | output | 12 | Non-prefetchable window base |
| np_limit | output | 12 | Non-prefetchable window limit |
| pf_base | output | 44 | Prefetchable window base, joined from two slots |
| pf_limit | output | 44 | Prefetchable window limit, joined from two slots |
| pm_ctl_sts | output | 32 | Power management control/status |
| msix_ctl | output | 16 | MSI-X control |
| msi_ctl | output | 16 | MSI control |
| tc_vc_map | output | 24 | Traffic class to virtual channel map |
| bus_dev | output | 13 | Bus and device number |
| payload_bytes | output | 13 | Maximum payload in bytes |
| rdreq_bytes | output | 13 | Maximum read request in bytes |
| payload_rsvd | output | 1 | Payload size code is reserved |
| rdreq_rsvd | output | 1 | Read request size code is reserved |
| all_valid | output | 1 | Every slot has been captured since reset |

## Verification
The assertions assume three things about the producer:
- `cfg_tog` is low while reset is applied.
- `cfg_tog` changes at most once in any three local cycles, so no edge is merged with the next one.
- `cfg_addr` and `cfg_data` are already stable when the toggle changes, and they stay stable until the change has passed through the synchronizer.

The stimulus meets these conditions with a model producer on a separate 100 MHz clock. For each word it sets the address and data together with the toggle, then holds them for eight producer cycles (about ten local cycles). When the bench drives address and data noise without a toggle, it does so only after all earlier words have settled.

// File: rtl/cfgsh_pkg.sv
package cfgsh_pkg;
  localparam int unsigned CFG_DATA_W = 32;
  localparam int unsigned CFG_ADDR_W = 4;
  localparam int unsigned CFG_NSLOT  = 1 << CFG_ADDR_W;
  localparam int unsigned SZ_CODE_W  = 3;
  localparam int unsigned SZ_BYTES_W = 13;
  localparam int unsigned SZ_MIN     = 128;
  localparam int unsigned SZ_MAXCODE = 5;

  typedef enum logic [CFG_ADDR_W-1:0] {
    SL_DEV    = 4'h0, SL_SLOT  = 4'h1, SL_LINK  = 4'h2, SL_PRIM  = 4'h3,
    SL_SEC    = 4'h4, SL_IOB   = 4'h5, SL_IOL   = 4'h6, SL_NP    = 4'h7,
    SL_PFB_LO = 4'h8, SL_PFB_HI = 4'h9, SL_PFL_LO = 4'hA, SL_PFL_HI = 4'hB,
    SL_PM     = 4'hC, SL_MSI   = 4'hD, SL_TCVC  = 4'hE, SL_BDF   = 4'hF
  } slot_id_e;
endpackage

// File: rtl/cfgsh_sync.sv
module cfgsh_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tog_async,
  output logic rst_sync_n,
  output logic edge_o
);
  localparam int unsigned RST_STAGES = 2;

  logic [RST_STAGES-1:0] rst_pipe_q, rst_pipe_d;
  logic [STAGES:0]       tog_q, tog_d;

  // reset: asserted at once, released through a short flop chain
  always_comb rst_pipe_d = {rst_pipe_q[RST_STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= rst_pipe_d;
  end

  assign rst_sync_n = rst_pipe_q[RST_STAGES-1];

  // toggle chain: STAGES synchronizing flops plus one history flop
  always_comb tog_d = {tog_q[STAGES-1:0], tog_async};

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) tog_q <= '0;
    else             tog_q <= tog_d;
  end

  assign edge_o = tog_q[STAGES] ^ tog_q[STAGES-1];
endmodule

// File: rtl/cfgsh_slot_bank.sv
module cfgsh_slot_bank #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 4,
  localparam int unsigned NSLOT = 1 << ADDR_W
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cap_en,
  input  logic [ADDR_W-1:0]            cap_addr,
  input  logic [DATA_W-1:0]            cap_data,
  output logic [NSLOT-1:0][DATA_W-1:0] slots_o,
  output logic                         all_valid_o
);
  logic [NSLOT-1:0][DATA_W-1:0] slots_q, slots_d;
  logic [NSLOT-1:0]             seen_q, seen_d;
  logic                         all_valid_q, all_valid_d;

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    logic hit;
    assign hit = cap_en && (cap_addr == ADDR_W'(g));

    always_comb begin
      slots_d[g] = slots_q[g];
      seen_d[g]  = seen_q[g];
      if (hit) begin
        slots_d[g] = cap_data;
        seen_d[g]  = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slots_q[g] <= '0;
        seen_q[g]  <= 1'b0;
      end else begin
        slots_q[g] <= slots_d[g];
        seen_q[g]  <= seen_d[g];
      end
    end
  end

  always_comb all_valid_d = &seen_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) all_valid_q <= 1'b0;
    else        all_valid_q <= all_valid_d;
  end

  assign slots_o     = slots_q;
  assign all_valid_o = all_valid_q;

  // R3: the shadows move only on a capture
  p_hold_no_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |=> $stable(slots_q));
  // R10: a slot once seen stays seen
  p_seen_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((seen_q & $past(seen_q)) == $past(seen_q)));
  // R10: the complete flag rises only as the result of a capture
  p_all_valid_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(all_valid_q) |-> $past(cap_en));
endmodule

// File: rtl/cfgsh_size_dec.sv
module cfgsh_size_dec #(
  parameter int unsigned CODE_W   = 3,
  parameter int unsigned BYTES_W  = 13,
  parameter int unsigned MIN_SIZE = 128,
  parameter int unsigned MAX_CODE = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [CODE_W-1:0]  code,
  output logic [BYTES_W-1:0] bytes_o,
  output logic               rsvd_o
);
  localparam logic [CODE_W-1:0]  LAST_OK = CODE_W'(MAX_CODE);
  localparam logic [BYTES_W-1:0] BASE    = BYTES_W'(MIN_SIZE);

  logic [BYTES_W-1:0] bytes_q, bytes_d;
  logic               rsvd_q, rsvd_d;

  always_comb begin
    bytes_d = bytes_q;
    rsvd_d  = rsvd_q;
    if (load) begin
      if (code <= LAST_OK) begin
        bytes_d = BASE << code;
        rsvd_d  = 1'b0;
      end else begin
        rsvd_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bytes_q <= '0;
      rsvd_q  <= 1'b0;
    end else begin
      bytes_q <= bytes_d;
      rsvd_q  <= rsvd_d;
    end
  end

  assign bytes_o = bytes_q;
  assign rsvd_o  = rsvd_q;

  // R5: the count is zero or a single power of two no smaller than the base
  p_bytes_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bytes_q) && (bytes_q == '0 || bytes_q >= BASE));
  // R5: a defined code clears the flag and yields a nonzero count
  p_code_ok_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (load && code <= LAST_OK) |=> (!rsvd_q && bytes_q != '0));
  // R6: a reserved code raises the flag and keeps the count
  p_rsvd_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (load && code > LAST_OK) |=> (rsvd_q && $stable(bytes_q)));
endmodule

// File: rtl/cfg_shadow_capture.sv
module cfg_shadow_capture
  import cfgsh_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_tog,
  input  logic [3:0]  cfg_addr,
  input  logic [31:0] cfg_data,
  output logic [15:0] dev_ctl,
  output logic [15:0] dev_ctl2,
  output logic [31:0] slot_ctl_sts,
  output logic [15:0] link_ctl,
  output logic [15:0] link_ctl2,
  output logic [15:0] prim_sts,
  output logic [7:0]  root_ctl,
  output logic [15:0] sec_sts,
  output logic [7:0]  sec_bus,
  output logic [7:0]  sub_bus,
  output logic [19:0] io_base,
  output logic [19:0] io_limit,
  output logic [11:0] np_base,
  output logic [11:0] np_limit,
  output logic [43:0] pf_base,
  output logic [43:0] pf_limit,
  output logic [31:0] pm_ctl_sts,
  output logic [15:0] msix_ctl,
  output logic [15:0] msi_ctl,
  output logic [23:0] tc_vc_map,
  output logic [12:0] bus_dev,
  output logic [12:0] payload_bytes,
  output logic [12:0] rdreq_bytes,
  output logic        payload_rsvd,
  output logic        rdreq_rsvd,
  output logic        all_valid
);
  localparam int unsigned NSIZE = 2;
  // position of each size code inside the slot-0 word (device control is the upper half)
  localparam int unsigned PAY_LSB = 16 + 5;
  localparam int unsigned RRQ_LSB = 16 + 12;

  logic                                 rst_sync_n;
  logic                                 cap_en;
  logic [CFG_NSLOT-1:0][CFG_DATA_W-1:0] sl;
  logic                                 size_load;
  logic [NSIZE-1:0][SZ_BYTES_W-1:0]     size_bytes;
  logic [NSIZE-1:0]                     size_rsvd;

  cfgsh_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .tog_async  (cfg_tog),
    .rst_sync_n (rst_sync_n),
    .edge_o     (cap_en)
  );

  cfgsh_slot_bank #(.DATA_W(CFG_DATA_W), .ADDR_W(CFG_ADDR_W)) u_bank (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .cap_en      (cap_en),
    .cap_addr    (cfg_addr),
    .cap_data    (cfg_data),
    .slots_o     (sl),
    .all_valid_o (all_valid)
  );

  assign size_load = cap_en && (cfg_addr == SL_DEV);

  for (genvar s = 0; s < NSIZE; s++) begin : g_size
    localparam int unsigned LSB = (s == 0) ? PAY_LSB : RRQ_LSB;
    cfgsh_size_dec #(
      .CODE_W (SZ_CODE_W), .BYTES_W (SZ_BYTES_W),
      .MIN_SIZE (SZ_MIN),  .MAX_CODE (SZ_MAXCODE)
    ) u_dec (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .load    (size_load),
      .code    (cfg_data[LSB +: SZ_CODE_W]),
      .bytes_o (size_bytes[s]),
      .rsvd_o  (size_rsvd[s])
    );
  end

  assign payload_bytes = size_bytes[0];
  assign rdreq_bytes   = size_bytes[1];
  assign payload_rsvd  = size_rsvd[0];
  assign rdreq_rsvd    = size_rsvd[1];

  // field extraction
  assign dev_ctl      = sl[SL_DEV][31:16];
  assign dev_ctl2     = sl[SL_DEV][15:0];
  assign slot_ctl_sts = sl[SL_SLOT];
  assign link_ctl     = sl[SL_LINK][31:16];
  assign link_ctl2    = sl[SL_LINK][15:0];
  assign prim_sts     = sl[SL_PRIM][23:8];
  assign root_ctl     = sl[SL_PRIM][7:0];
  assign sec_sts      = sl[SL_SEC][31:16];
  assign sec_bus      = sl[SL_SEC][15:8];
  assign sub_bus      = sl[SL_SEC][7:0];
  assign io_base      = sl[SL_IOB][19:0];
  assign io_limit     = sl[SL_IOL][19:0];
  assign np_base      = sl[SL_NP][23:12];
  assign np_limit     = sl[SL_NP][11:0];
  assign pf_base      = {sl[SL_PFB_HI][11:0], sl[SL_PFB_LO]};
  assign pf_limit     = {sl[SL_PFL_HI][11:0], sl[SL_PFL_LO]};
  assign pm_ctl_sts   = sl[SL_PM];
  assign msix_ctl     = sl[SL_MSI][31:16];
  assign msi_ctl      = sl[SL_MSI][15:0];
  assign tc_vc_map    = sl[SL_TCVC][23:0];
  assign bus_dev      = sl[SL_BDF][12:0];

  logic unused_bits;
  assign unused_bits = ^{sl[SL_PRIM][31:24], sl[SL_IOB][31:20], sl[SL_IOL][31:20],
                         sl[SL_NP][31:24], sl[SL_PFB_HI][31:12], sl[SL_PFL_HI][31:12],
                         sl[SL_TCVC][31:24], sl[SL_BDF][31:13]};

  // R8: the wide base moves only when one of its two halves is captured
  p_pf_base_src_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(cap_en && (cfg_addr == SL_PFB_LO || cfg_addr == SL_PFB_HI)) |=> $stable(pf_base));
  // R5: the byte counts change only on a capture of slot 0
  p_size_src_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !size_load |=> ($stable(payload_bytes) && $stable(rdreq_bytes)));
endmodule

// File: tb/cfg_shadow_capture_tb_top.sv
module cfg_shadow_capture_tb_top;
  logic clk = 1'b0;
  logic prod_clk = 1'b0;
  logic rst_n;
  logic cfg_tog;
  logic [3:0]  cfg_addr;
  logic [31:0] cfg_data;

  logic [15:0] dev_ctl, dev_ctl2, link_ctl, link_ctl2, prim_sts, sec_sts, msix_ctl, msi_ctl;
  logic [31:0] slot_ctl_sts, pm_ctl_sts;
  logic [7:0]  root_ctl, sec_bus, sub_bus;
  logic [19:0] io_base, io_limit;
  logic [11:0] np_base, np_limit;
  logic [43:0] pf_base, pf_limit;
  logic [23:0] tc_vc_map;
  logic [12:0] bus_dev, payload_bytes, rdreq_bytes;
  logic        payload_rsvd, rdreq_rsvd, all_valid;

  always #4 clk = ~clk;        // 125 MHz local clock
  always #5 prod_clk = ~prod_clk; // 100 MHz producer clock

  cfg_shadow_capture dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_tog(cfg_tog), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .dev_ctl(dev_ctl), .dev_ctl2(dev_ctl2), .slot_ctl_sts(slot_ctl_sts),
    .link_ctl(link_ctl), .link_ctl2(link_ctl2), .prim_sts(prim_sts), .root_ctl(root_ctl),
    .sec_sts(sec_sts), .sec_bus(sec_bus), .sub_bus(sub_bus),
    .io_base(io_base), .io_limit(io_limit), .np_base(np_base), .np_limit(np_limit),
    .pf_base(pf_base), .pf_limit(pf_limit), .pm_ctl_sts(pm_ctl_sts),
    .msix_ctl(msix_ctl), .msi_ctl(msi_ctl), .tc_vc_map(tc_vc_map), .bus_dev(bus_dev),
    .payload_bytes(payload_bytes), .rdreq_bytes(rdreq_bytes),
    .payload_rsvd(payload_rsvd), .rdreq_rsvd(rdreq_rsvd), .all_valid(all_valid)
  );

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  bit done = 0;
  bit cmp_en = 0;

  // behavioural reference state
  logic [31:0] es [16];
  bit          seen [16];
  int          n_seen = 0;
  int          exp_pay = 0, exp_rrq = 0;
  bit          exp_pay_rsvd = 0, exp_rrq_rsvd = 0;

  task automatic chk(input string tag, input string nm, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, nm, act, exp, $time);
    end
  endtask

  // per-clock comparison against the reference, away from the active edge
  always @(negedge clk) begin
    if (cmp_en && !done) begin
      chk("R4",  "dev_ctl",      dev_ctl,      es[0][31:16]);
      chk("R4",  "dev_ctl2",     dev_ctl2,     es[0][15:0]);
      chk("R2",  "slot_ctl_sts", slot_ctl_sts, es[1]);
      chk("R11", "link_ctl",     link_ctl,     es[2][31:16]);
      chk("R11", "link_ctl2",    link_ctl2,    es[2][15:0]);
      chk("R11", "prim_sts",     prim_sts,     es[3][23:8]);
      chk("R11", "root_ctl",     root_ctl,     es[3][7:0]);
      chk("R7",  "sec_sts",      sec_sts,      es[4][31:16]);
      chk("R7",  "sec_bus",      sec_bus,      es[4][15:8]);
      chk("R7",  "sub_bus",      sub_bus,      es[4][7:0]);
      chk("R7",  "io_base",      io_base,      es[5][19:0]);
      chk("R7",  "io_limit",     io_limit,     es[6][19:0]);
      chk("R11", "np_base",      np_base,      es[7][23:12]);
      chk("R11", "np_limit",     np_limit,     es[7][11:0]);
      chk("R8",  "pf_base",      pf_base,      {es[9][11:0], es[8]});
      chk("R8",  "pf_limit",     pf_limit,     {es[11][11:0], es[10]});
      chk("R11", "pm_ctl_sts",   pm_ctl_sts,   es[12]);
      chk("R11", "msix_ctl",     msix_ctl,     es[13][31:16]);
      chk("R11", "msi_ctl",      msi_ctl,      es[13][15:0]);
      chk("R11", "tc_vc_map",    tc_vc_map,    es[14][23:0]);
      chk("R9",  "bus_dev",      bus_dev,      es[15][12:0]);
      chk("R5",  "payload_bytes", payload_bytes, 64'(exp_pay));
      chk("R5",  "rdreq_bytes",  rdreq_bytes,  64'(exp_rrq));
      chk("R6",  "payload_rsvd", payload_rsvd, exp_pay_rsvd);
      chk("R6",  "rdreq_rsvd",   rdreq_rsvd,   exp_rrq_rsvd);
      chk("R10", "all_valid",    all_valid,    n_seen == 16);
    end
  end

  task automatic size_model(input logic [2:0] c, inout int bytes, inout bit rsvd);
    if (c <= 3'd5) begin
      bytes = 128 << c;
      rsvd  = 0;
    end else begin
      rsvd  = 1;
    end
  endtask

  task automatic put_slot(input logic [3:0] a, input logic [31:0] d);
    cmp_en = 0;
    @(posedge prod_clk);
    cfg_addr = a;
    cfg_data = d;
    cfg_tog  = ~cfg_tog;
    repeat (6) @(posedge prod_clk);
    es[a] = d;
    if (!seen[a]) begin
      seen[a] = 1;
      n_seen++;
    end
    if (a == 4'h0) begin
      size_model(d[23:21], exp_pay, exp_pay_rsvd);
      size_model(d[30:28], exp_rrq, exp_rrq_rsvd);
    end
    cmp_en = 1;
    repeat (2) @(posedge prod_clk);
  endtask

  task automatic put_dev(input logic [2:0] pay, input logic [2:0] rrq);
    logic [15:0] w;
    w = 16'($urandom);
    w[14:12] = rrq;
    w[7:5]   = pay;
    put_slot(4'h0, {w, 16'($urandom)});
  endtask

  task automatic round_rest(input bit skip_last);
    for (int a = 1; a < 16; a++) begin
      if (!(skip_last && a == 15)) put_slot(4'(a), $urandom);
    end
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin
      es[i] = '0;
      seen[i] = 0;
    end
    rst_n = 1'b0;
    cfg_tog = 1'b0;
    cfg_addr = '0;
    cfg_data = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk("R1", "all_valid after reset", all_valid, 0);
    chk("R1", "payload_bytes after reset", payload_bytes, 0);
    chk("R1", "pf_base after reset", pf_base, 0);
    cmp_en = 1;
    repeat (10) @(negedge clk);

    // first round: payload code 1 (256), read request code 2 (512)
    put_dev(3'd1, 3'd2);
    round_rest(1);
    @(negedge clk);
    chk("R10", "all_valid before last slot", all_valid, 0);
    put_slot(4'hF, 32'hFFFF_E123);   // upper bits set, must be ignored (R9)
    @(negedge clk);
    chk("R10", "all_valid after all slots", all_valid, 1);
    chk("R9", "bus_dev masked", bus_dev, 13'h0123);
    chk("R5", "payload 256", payload_bytes, 256);

    // R3: address and data noise without a toggle
    for (int k = 0; k < 10; k++) begin
      @(posedge prod_clk);
      cfg_addr = 4'($urandom);
      cfg_data = $urandom;
    end
    @(negedge clk);
    chk("R3", "pf_base after noise", pf_base, {es[9][11:0], es[8]});
    chk("R3", "dev_ctl after noise", dev_ctl, es[0][31:16]);

    // second round: extremes, ignored upper bits in split and I/O slots
    put_dev(3'd5, 3'd0);
    round_rest(0);
    put_slot(4'h9, 32'hABCDE_FED);
    put_slot(4'hB, 32'h12345_001);
    put_slot(4'h5, 32'hFFF_0000F);
    @(negedge clk);
    chk("R8", "pf_base upper join", pf_base[43:32], 12'hFED);
    chk("R8", "pf_limit upper join", pf_limit[43:32], 12'h001);
    chk("R7", "io_base masked", io_base, 20'h0000F);
    chk("R5", "payload 4096", payload_bytes, 4096);
    chk("R5", "rdreq 128", rdreq_bytes, 128);

    // R6: reserved codes keep the previous counts
    put_dev(3'd6, 3'd7);
    @(negedge clk);
    chk("R6", "payload held", payload_bytes, 4096);
    chk("R6", "rdreq held", rdreq_bytes, 128);
    chk("R6", "payload flag", payload_rsvd, 1);
    chk("R6", "rdreq flag", rdreq_rsvd, 1);
    put_dev(3'd7, 3'd6);

    // R5: sweep of all defined codes
    for (int c = 0; c < 6; c++) begin
      put_dev(3'(c), 3'(5 - c));
      @(negedge clk);
      chk("R5", "payload sweep", payload_bytes, 64'(128 << c));
      chk("R5", "rdreq sweep", rdreq_bytes, 64'(128 << (5 - c)));
      chk("R6", "flag cleared", payload_rsvd, 0);
    end

    // R2: a falling and a rising toggle each capture
    put_slot(4'h1, 32'h5A5A_0001);
    put_slot(4'h1, 32'hA5A5_0002);
    @(negedge clk);
    chk("R2", "slot 1 second capture", slot_ctl_sts, 32'hA5A5_0002);

    repeat (10) @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !done) begin
      done = 1;
      n_err++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule